// File: doc/BRIEF.md
# SPI Header Responder (Peripheral Side)

This block is the peripheral end of a framed SPI link. It watches chip select and SPI clock, both sampled in the local clock domain. It reports readiness on an IRQ output. Every transaction opens with a five-byte header exchange. The master sends a control byte followed by four zero bytes. In the same five byte slots the block returns a start byte, then its write-buffer size, then its read-buffer size. Each size is 16 bits and goes out low byte first. Every byte on the wire is sent most significant bit first, in SPI mode 0.

After the header, the control byte selects one of three outcomes:

- A write transaction pushes received payload bytes into a local sink FIFO.
- A read transaction pops bytes from a local source FIFO and shifts them out.
- Any other control value abandons the payload and raises an error flag.

Transfers beyond the sizes advertised in the header are ignored. IRQ rises ahead of chip select when read data is pending. If the master starts without IRQ, the block models a wake-up delay before IRQ rises. IRQ falls once the header is done. After chip select is released, IRQ is held low for a fixed gap before it may signal pending data again. The header values are captured while IRQ is low and frozen while it is high.

Top module: `spi_hdr_responder`

## Requirements
- R1: While reset is held and right after it, IRQ, MISO, the error flag, the push strobe and the pop strobe are all low.
- R2: The reply header is sent in this order: the START_BYTE value (default 0x02), write size bits 7:0, write size bits 15:8, read size bits 7:0, read size bits 15:8. Every byte is sent MSB first, with MOSI sampled on rising SCLK.
- R3: With chip select high and a non-zero read size, IRQ rises before chip select falls. A transaction that starts in this state serves its header without any wake delay.
- R4: If IRQ is low when chip select falls, IRQ stays low for WAKE_CYC cycles after chip select is seen low, then rises. The header then reports a read size of 0.
- R5: Size-input changes made while IRQ is high do not alter the header or the payload limits of that transaction.
- R6: IRQ falls after the fifth header byte has been received.
- R7: Control byte 0x0B (read) pops one source-FIFO byte per payload slot, up to the advertised read size, and only while the FIFO is non-empty. Slots beyond that size send 0x00 and pop nothing.
- R8: Control byte 0x0A (write) pushes received payload bytes into the sink FIFO, up to the advertised write size. Later bytes are dropped.
- R9: Any other control byte sets the error flag and suppresses every push and pop. The flag clears when the next header begins.
- R10: After chip select rises, IRQ stays low for GAP_CYC cycles. It then rises only if the read size is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock from the master |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Master-to-peripheral data |
| spi_miso | output | 1 | Peripheral-to-master data |
| irq_o | output | 1 | Readiness / pending-data indication |
| wbuf_size_i | input | SIZE_W | Free space for master writes |
| rbuf_size_i | input | SIZE_W | Bytes waiting to be read |
| rd_data_i | input | 8 | Source FIFO head byte |
| rd_valid_i | input | 1 | Source FIFO non-empty |
| rd_pop_o | output | 1 | Source FIFO pop strobe |
| wr_data_o | output | 8 | Byte to the sink FIFO |
| wr_push_o | output | 1 | Sink FIFO push strobe |
| ctrl_err_o | output | 1 | Invalid control byte seen |

## Verification
The SPI pins pass through SYNC_STAGES flops, so every pin event reaches the controller about three local cycles late.

- **Wake and gap windows:** the IRQ rise after a wake, and the IRQ rise after a gap, land near WAKE_CYC or GAP_CYC plus three cycles. The bench samples IRQ well inside each window, at 30 and 55 cycles for the wake and at 20 and 45 cycles for the gap. It never samples on the boundary itself.
- **Bit timing:** the bench master holds each SCLK phase for eight cycles. A MISO bit is therefore settled about five cycles after the previous rising edge, and the bench reads it just before the next one.
- **Strobes:** pushes and pops are counted at every clock edge.
- **IRQ after the header and the error flag:** both are read ten cycles after the header's last edge.

// File: rtl/shr_pkg.sv
package shr_pkg;

   localparam int HDR_BYTES = 5;
   localparam logic [7:0] CTRL_WRITE = 8'h0A;
   localparam logic [7:0] CTRL_READ  = 8'h0B;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAKE,
      ST_HDR,
      ST_DATA,
      ST_HOLD,
      ST_GAP
   } shr_state_e;

   typedef enum logic [1:0] {
      OP_WRITE,
      OP_READ,
      OP_BAD
   } shr_op_e;

   function automatic shr_op_e decode_ctrl(input logic [7:0] b);
      if (b == CTRL_WRITE) return OP_WRITE;
      if (b == CTRL_READ)  return OP_READ;
      return OP_BAD;
   endfunction

endpackage

// File: rtl/shr_pin_sync.sv
module shr_pin_sync #(
   parameter int          N       = 3,
   parameter int          STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o
);

   for (genvar g = 0; g < N; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
         else        chain <= {chain[STAGES-2:0], d_i[g]};
      end
      assign q_o[g] = chain[STAGES-1];
   end

endmodule

// File: rtl/shr_shifter.sv
module shr_shifter (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active_i,
   input  logic       sclk_i,
   input  logic       mosi_i,
   input  logic       ld_i,
   input  logic [7:0] ld_byte_i,
   output logic       miso_o,
   output logic       done_o,
   output logic [7:0] rx_byte_o
);

   logic       sclk_d;
   logic       rise;
   logic [2:0] bit_q;
   logic [7:0] tx_sr;
   logic [6:0] rx_sr;

   assign rise = sclk_i & ~sclk_d & active_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d    <= 1'b0;
         bit_q     <= '0;
         tx_sr     <= '0;
         rx_sr     <= '0;
         done_o    <= 1'b0;
         rx_byte_o <= '0;
      end else begin
         sclk_d <= sclk_i;
         done_o <= 1'b0;
         if (!active_i) begin
            bit_q <= '0;
            tx_sr <= '0;
         end else begin
            if (ld_i)      tx_sr <= ld_byte_i;
            else if (rise) tx_sr <= {tx_sr[6:0], 1'b0};
            if (rise) begin
               rx_sr <= {rx_sr[5:0], mosi_i};
               bit_q <= bit_q + 3'd1;
               if (bit_q == 3'd7) begin
                  done_o    <= 1'b1;
                  rx_byte_o <= {rx_sr, mosi_i};
               end
            end
         end
      end
   end

   assign miso_o = active_i & tx_sr[7];

endmodule

// File: rtl/shr_txn_ctrl.sv
module shr_txn_ctrl
   import shr_pkg::*;
#(
   parameter int         SIZE_W     = 16,
   parameter int         WAKE_CYC   = 40,
   parameter int         GAP_CYC    = 24,
   parameter logic [7:0] START_BYTE = 8'h02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_low_i,
   input  logic              done_i,
   input  logic [7:0]        rx_byte_i,
   input  logic [SIZE_W-1:0] wbuf_i,
   input  logic [SIZE_W-1:0] rbuf_i,
   input  logic              rd_valid_i,
   input  logic [7:0]        rd_data_i,
   output logic              ld_o,
   output logic [7:0]        ld_byte_o,
   output logic              rd_pop_o,
   output logic              wr_push_o,
   output logic [7:0]        wr_data_o,
   output logic              irq_o,
   output logic              err_o,
   output logic [31:0]       snap_o
);

   localparam int TMR_MAX = (WAKE_CYC > GAP_CYC) ? WAKE_CYC : GAP_CYC;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);
   localparam logic [TMR_W-1:0] WAKE_END = TMR_W'(WAKE_CYC - 1);
   localparam logic [TMR_W-1:0] GAP_END  = TMR_W'(GAP_CYC - 1);
   localparam logic [2:0] IDX_LAST = 3'(HDR_BYTES - 1);

   shr_state_e       state_q;
   shr_op_e          op_q, op_dec, cur_op;
   logic             irq_q, err_q;
   logic [7:0]       ctrl_q;
   logic [2:0]       idx_q;
   logic [15:0]      cnt_q, lim_q, cur_cnt, cur_lim;
   logic [15:0]      snap_w_q, snap_r_q;
   logic [TMR_W-1:0] tmr_q;
   logic             pending, hdr_last, enter_hdr, pay_slot;
   logic [7:0]       hdr_next;

   assign pending = |rbuf_i;

   always_comb begin
      op_dec    = decode_ctrl(ctrl_q);
      hdr_last  = (state_q == ST_HDR) && (idx_q == IDX_LAST);
      enter_hdr = cs_low_i && (((state_q == ST_IDLE) && irq_q) ||
                               ((state_q == ST_WAKE) && (tmr_q == WAKE_END)));
      cur_op    = (state_q == ST_HDR) ? op_dec : op_q;
      cur_cnt   = hdr_last ? 16'd0 : cnt_q;
      cur_lim   = hdr_last ? ((op_dec == OP_READ) ? snap_r_q : snap_w_q) : lim_q;
      pay_slot  = done_i && (hdr_last || (state_q == ST_DATA));
      rd_pop_o  = pay_slot && (cur_op == OP_READ) && (cur_cnt < cur_lim) && rd_valid_i;
      wr_push_o = done_i && (state_q == ST_DATA) && (op_q == OP_WRITE) && (cnt_q < lim_q);
      wr_data_o = rx_byte_i;
      ld_o      = enter_hdr || (done_i && ((state_q == ST_HDR) || (state_q == ST_DATA) ||
                                           (state_q == ST_HOLD)));
      case (idx_q)
         3'd0:    hdr_next = snap_w_q[7:0];
         3'd1:    hdr_next = snap_w_q[15:8];
         3'd2:    hdr_next = snap_r_q[7:0];
         default: hdr_next = snap_r_q[15:8];
      endcase
      if (enter_hdr)                            ld_byte_o = START_BYTE;
      else if ((state_q == ST_HDR) && !hdr_last) ld_byte_o = hdr_next;
      else if (rd_pop_o)                        ld_byte_o = rd_data_i;
      else                                      ld_byte_o = 8'h00;
   end

   // header snapshot follows the inputs only while IRQ is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_w_q <= '0;
         snap_r_q <= '0;
      end else if (!irq_q) begin
         snap_w_q <= 16'(wbuf_i);
         snap_r_q <= (state_q == ST_WAKE) ? 16'd0 : 16'(rbuf_i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_BAD;
         irq_q   <= 1'b0;
         err_q   <= 1'b0;
         ctrl_q  <= '0;
         idx_q   <= '0;
         cnt_q   <= '0;
         lim_q   <= '0;
         tmr_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cs_low_i) begin
                  if (irq_q) begin
                     state_q <= ST_HDR;
                     idx_q   <= '0;
                     err_q   <= 1'b0;
                  end else begin
                     state_q <= ST_WAKE;
                     tmr_q   <= '0;
                  end
               end else begin
                  irq_q <= pending;
               end
            end
            ST_WAKE: begin
               if (!cs_low_i) begin
                  state_q <= ST_GAP;
                  tmr_q   <= '0;
               end else if (tmr_q == WAKE_END) begin
                  state_q <= ST_HDR;
                  irq_q   <= 1'b1;
                  idx_q   <= '0;
                  err_q   <= 1'b0;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            ST_HDR, ST_DATA, ST_HOLD: begin
               if (!cs_low_i) begin
                  state_q <= ST_GAP;
                  tmr_q   <= '0;
                  irq_q   <= 1'b0;
               end else if (done_i) begin
                  if (state_q == ST_HDR) begin
                     if (idx_q == 3'd0) ctrl_q <= rx_byte_i;
                     if (hdr_last) begin
                        irq_q <= 1'b0;
                        op_q  <= op_dec;
                        lim_q <= cur_lim;
                        cnt_q <= (op_dec == OP_READ) ? 16'd1 : 16'd0;
                        if (op_dec == OP_BAD) begin
                           err_q   <= 1'b1;
                           state_q <= ST_HOLD;
                        end else begin
                           state_q <= ST_DATA;
                        end
                     end else begin
                        idx_q <= idx_q + 3'd1;
                     end
                  end else if (state_q == ST_DATA) begin
                     if (cnt_q != 16'hFFFF) cnt_q <= cnt_q + 16'd1;
                  end
               end
            end
            ST_GAP: begin
               if (tmr_q == GAP_END) state_q <= ST_IDLE;
               else                  tmr_q   <= tmr_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign irq_o  = irq_q;
   assign err_o  = err_q;
   assign snap_o = {snap_w_q, snap_r_q};

endmodule

// File: rtl/spi_hdr_responder.sv
module spi_hdr_responder #(
   parameter int         SIZE_W      = 16,
   parameter int         WAKE_CYC    = 40,
   parameter int         GAP_CYC     = 24,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] START_BYTE  = 8'h02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              irq_o,
   input  logic [SIZE_W-1:0] wbuf_size_i,
   input  logic [SIZE_W-1:0] rbuf_size_i,
   input  logic [7:0]        rd_data_i,
   input  logic              rd_valid_i,
   output logic              rd_pop_o,
   output logic [7:0]        wr_data_o,
   output logic              wr_push_o,
   output logic              ctrl_err_o
);

   localparam int PIN_N = 3;

   if (SIZE_W < 1 || SIZE_W > 16) begin : g_bad_size
      $error("SIZE_W must be 1..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (WAKE_CYC < 1 || GAP_CYC < 1) begin : g_bad_timer
      $error("WAKE_CYC and GAP_CYC must be at least 1");
   end

   logic [PIN_N-1:0] pins_s;
   logic             done, ld;
   logic [7:0]       rx_byte, ld_byte;
   logic [31:0]      hdr_snap;

   shr_pin_sync #(
      .N       (PIN_N),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({spi_cs_n, spi_mosi, spi_sclk}),
      .q_o   (pins_s)
   );

   shr_shifter u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .active_i  (~pins_s[2]),
      .sclk_i    (pins_s[0]),
      .mosi_i    (pins_s[1]),
      .ld_i      (ld),
      .ld_byte_i (ld_byte),
      .miso_o    (spi_miso),
      .done_o    (done),
      .rx_byte_o (rx_byte)
   );

   shr_txn_ctrl #(
      .SIZE_W     (SIZE_W),
      .WAKE_CYC   (WAKE_CYC),
      .GAP_CYC    (GAP_CYC),
      .START_BYTE (START_BYTE)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_low_i   (~pins_s[2]),
      .done_i     (done),
      .rx_byte_i  (rx_byte),
      .wbuf_i     (wbuf_size_i),
      .rbuf_i     (rbuf_size_i),
      .rd_valid_i (rd_valid_i),
      .rd_data_i  (rd_data_i),
      .ld_o       (ld),
      .ld_byte_o  (ld_byte),
      .rd_pop_o   (rd_pop_o),
      .wr_push_o  (wr_push_o),
      .wr_data_o  (wr_data_o),
      .irq_o      (irq_o),
      .err_o      (ctrl_err_o),
      .snap_o     (hdr_snap)
   );

endmodule

// File: rtl/shr_checker.sv
module shr_checker #(
   parameter int GAP_CYC     = 24,
   parameter int SYNC_STAGES = 2
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cs_n,
   input logic        irq,
   input logic        wr_push,
   input logic        rd_pop,
   input logic        rd_valid,
   input logic        err,
   input logic [31:0] snap
);

   localparam int WIN_LO = SYNC_STAGES + 1;
   localparam int WIN_HI = GAP_CYC + SYNC_STAGES;

   int unsigned gcnt;
   logic        cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gcnt <= 0;
         cs_q <= 1'b1;
      end else begin
         cs_q <= cs_n;
         if (cs_n && !cs_q)                  gcnt <= 1;
         else if (gcnt != 0 && gcnt < WIN_HI) gcnt <= gcnt + 1;
         else                                 gcnt <= 0;
      end
   end

   AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pop |-> rd_valid); // R7
   AST_PUSH_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_push |-> !irq); // R8
   AST_ERR_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!wr_push && !rd_pop)); // R9
   AST_SNAP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && $past(irq)) |-> $stable(snap)); // R5
   AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (gcnt > WIN_LO && gcnt <= WIN_HI) |-> !irq); // R10

endmodule

bind spi_hdr_responder shr_checker #(
   .GAP_CYC     (GAP_CYC),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (spi_cs_n),
   .irq      (irq_o),
   .wr_push  (wr_push_o),
   .rd_pop   (rd_pop_o),
   .rd_valid (rd_valid_i),
   .err      (ctrl_err_o),
   .snap     (hdr_snap)
);

// File: tb/sim_spi_hdr_responder.sv
module sim_spi_hdr_responder;

   localparam int         CLK_P = 10;
   localparam int         HP    = 8;
   localparam logic [7:0] START = 8'h02;
   localparam int         WD    = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic        spi_miso, irq_o, rd_pop_o, wr_push_o, ctrl_err_o;
   logic [15:0] wbuf = '0, rbuf = '0;
   logic [7:0]  wr_data_o, rd_data;
   logic        rd_valid;

   logic [7:0]  rdq [0:15];
   logic [7:0]  wrq [0:15];
   int          rd_head = 0, rd_tail = 0, wr_n = 0;
   int          checks = 0, fails = 0;
   logic        fin = 1'b0;
   logic [7:0]  rxh [0:4];
   logic        saw_strobe = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   assign rd_valid = rd_head < rd_tail;
   assign rd_data  = rdq[rd_head[3:0]];

   always @(posedge clk) begin
      if (rd_pop_o) rd_head <= rd_head + 1;
      if (wr_push_o) begin
         wrq[wr_n[3:0]] <= wr_data_o;
         wr_n <= wr_n + 1;
      end
      if (!rst_n && (wr_push_o || rd_pop_o)) saw_strobe <= 1'b1;
   end

   spi_hdr_responder u0 (
      .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq_o(irq_o),
      .wbuf_size_i(wbuf), .rbuf_size_i(rbuf), .rd_data_i(rd_data),
      .rd_valid_i(rd_valid), .rd_pop_o(rd_pop_o), .wr_data_o(wr_data_o),
      .wr_push_o(wr_push_o), .ctrl_err_o(ctrl_err_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clocks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         spi_mosi = tx[i];
         clocks(HP);
         rx[i] = spi_miso;
         spi_sclk = 1'b1;
         clocks(HP);
         spi_sclk = 1'b0;
      end
   endtask

   task automatic header(input logic [7:0] ctrl);
      logic [7:0] r;
      xfer(ctrl, r); rxh[0] = r;
      for (int k = 1; k < 5; k++) begin
         xfer(8'h00, r);
         rxh[k] = r;
      end
   endtask

   task automatic wait_irq(input logic lvl, input string req);
      int n = 0;
      while (irq_o !== lvl && n < 2000) begin
         clocks(1);
         n++;
      end
      chk(req, "irq level reached", int'(irq_o), int'(lvl));
   endtask

   task automatic t_reset();
      clocks(5);
      chk("R1", "irq in reset", int'(irq_o), 0);
      chk("R1", "miso in reset", int'(spi_miso), 0);
      chk("R1", "err in reset", int'(ctrl_err_o), 0);
      rst_n = 1'b1;
      clocks(3);
      chk("R1", "irq after reset", int'(irq_o), 0);
      chk("R1", "strobes", int'(saw_strobe | wr_push_o | rd_pop_o), 0);
   endtask

   task automatic t_read();
      logic [7:0] r;
      rdq[0] = 8'h11; rdq[1] = 8'h22; rdq[2] = 8'h33; rdq[3] = 8'h44;
      rd_tail = 4;
      wbuf = 16'h0123; rbuf = 16'd3;
      clocks(10);
      chk("R3", "irq before cs with pending read", int'(irq_o), 1);
      rbuf = 16'd7;                          // R5: change while IRQ high
      clocks(4);
      spi_cs_n = 1'b0;
      clocks(2*HP);
      header(8'h0B);
      chk("R2", "start byte", int'(rxh[0]), int'(START));
      chk("R2", "wbuf low", int'(rxh[1]), 8'h23);
      chk("R2", "wbuf high", int'(rxh[2]), 8'h01);
      chk("R5", "rbuf low frozen", int'(rxh[3]), 8'h03);
      chk("R2", "rbuf high", int'(rxh[4]), 8'h00);
      clocks(10);
      chk("R6", "irq low after header", int'(irq_o), 0);
      xfer(8'h00, r); chk("R7", "payload 0", int'(r), 8'h11);
      xfer(8'h00, r); chk("R7", "payload 1", int'(r), 8'h22);
      xfer(8'h00, r); chk("R7", "payload 2", int'(r), 8'h33);
      xfer(8'h00, r); chk("R7", "beyond size zero", int'(r), 8'h00);
      clocks(10);
      chk("R7", "pop count", rd_head, 3);
      chk("R8", "no push on read", wr_n, 0);
      spi_cs_n = 1'b1;                        // rbuf still 7: pending
      clocks(20);
      chk("R10", "irq held low in gap", int'(irq_o), 0);
      clocks(25);
      chk("R10", "irq back after gap", int'(irq_o), 1);
      rbuf = 16'd0;
      clocks(5);
      chk("R10", "irq drops without pending", int'(irq_o), 0);
   endtask

   task automatic t_write();
      logic [7:0] r;
      wbuf = 16'd2;
      clocks(5);
      spi_cs_n = 1'b0;
      clocks(30);
      chk("R4", "irq still low during wake", int'(irq_o), 0);
      clocks(25);
      chk("R4", "irq high after wake", int'(irq_o), 1);
      header(8'h0A);
      chk("R2", "wbuf low on write", int'(rxh[1]), 8'h02);
      chk("R4", "rbuf reported zero", int'({rxh[4], rxh[3]}), 0);
      xfer(8'hAA, r);
      xfer(8'hBB, r);
      xfer(8'hCC, r);
      clocks(10);
      chk("R8", "push count capped", wr_n, 2);
      chk("R8", "first pushed", int'(wrq[0]), 8'hAA);
      chk("R8", "second pushed", int'(wrq[1]), 8'hBB);
      spi_cs_n = 1'b1;
      clocks(60);
   endtask

   task automatic t_bad();
      logic [7:0] r;
      wbuf = 16'd4;
      spi_cs_n = 1'b0;
      wait_irq(1'b1, "R4");
      header(8'h55);
      clocks(10);
      chk("R9", "error flag set", int'(ctrl_err_o), 1);
      xfer(8'h77, r);
      clocks(10);
      chk("R9", "no push after bad ctrl", wr_n, 2);
      chk("R9", "no pop after bad ctrl", rd_head, 3);
      chk("R9", "miso zero after bad ctrl", int'(r), 0);
      spi_cs_n = 1'b1;
      clocks(60);
   endtask

   task automatic t_late_pending();
      logic [7:0] r;
      spi_cs_n = 1'b0;
      clocks(10);
      rbuf = 16'd5;                           // arrives during the wake
      wait_irq(1'b1, "R4");
      header(8'h0B);
      chk("R9", "error cleared on new header", int'(ctrl_err_o), 0);
      chk("R4", "rbuf zero when cs met low irq", int'({rxh[4], rxh[3]}), 0);
      xfer(8'h00, r);
      clocks(10);
      chk("R7", "zero-size read sends zero", int'(r), 0);
      chk("R7", "zero-size read pops nothing", rd_head, 3);
      rbuf = 16'd0;
      spi_cs_n = 1'b1;
      clocks(60);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      t_reset();
      t_read();
      t_write();
      t_bad();
      t_late_pending();
      fin = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (WD) @(posedge clk);
      if (!fin) begin
         fails++;
         $display("FAIL watchdog (all requirements): actual hung expected done");
         summary();
         $finish;
      end
   end

endmodule